// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Sense Control

This block compares a reference divider pulse train with an RF divider pulse train and drives two charge-pump commands, one that sources current and one that sinks it. Each input is detected on its rising edge. The reference edge arms an "advance" flag and the RF divider edge arms a "retard" flag. Once both flags are set, both stay active for a fixed overlap of `OVL` clock cycles and then clear together. That overlap keeps a correction pulse present even at zero phase error, so the detector has no dead band.

A sense input picks the loop polarity. It decides which internal flag drives the sourcing command and which drives the sinking command. It also swaps which divider signal appears on each of the two monitor outputs. A 2-bit gain code is translated into the charge-pump current multiplier, expressed in half units. A programming-hold input forces both pump commands inactive at once and clears the detector state.

Top module: `pfd_sense_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pump commands are low after that edge. Reset is synchronous.
- R2: An RF divider edge that leads a reference edge by d cycles (d > 0) gives a retard pulse of d+OVL cycles and an advance pulse of OVL cycles. The retard pulse drives `pump_snk` when `sense`=1 and `pump_src` when `sense`=0.
- R3: A reference edge that leads an RF divider edge by d cycles (d > 0) gives an advance pulse of d+OVL cycles and a retard pulse of OVL cycles. The advance pulse drives `pump_src` when `sense`=1 and `pump_snk` when `sense`=0.
- R4: With zero phase error (both edges sampled at the same clock edge), both pump commands are high for exactly OVL cycles, with either `sense` value.
- R5: The two pump commands are never both high for more than OVL consecutive cycles.
- R6: When `sense`=1, `mon_a` carries `div_in` and `mon_b` carries `ref_in`. When `sense`=0 the two are swapped.
- R7: `gain_x2` is twice the current multiplier: code 00 gives 2 (x1), 01 gives 3 (x1.5), 10 gives 5 (x2.5) and 11 gives 8 (x4).
- R8: While `prog_hold` is high, both pump commands are low in the same cycle and the detector state is cleared. In the first cycle after release, with quiet inputs, both commands stay low.
- R9: After a rising `div_in` sampled while `prog_hold` is low, at least one pump command is high in the next cycle unless hold is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference divider pulse, synchronous to clk |
| div_in | input | 1 | RF divider pulse, synchronous to clk |
| sense | input | 1 | Loop polarity and monitor swap select |
| gain_code | input | 2 | Charge-pump multiplier select |
| prog_hold | input | 1 | High while programming; forces pumps off |
| pump_src | output | 1 | Command to source charge-pump current |
| pump_snk | output | 1 | Command to sink charge-pump current |
| mon_a | output | 1 | Monitor output A (divider per `sense`) |
| mon_b | output | 1 | Monitor output B (the other divider) |
| gain_x2 | output | 4 | Current multiplier in half units |

## Verification
Two functions can fall in the same cycle: arming the late flag, and the overlap clear that follows it. When both edges arrive at one clock edge, arming and overlap start together. A new edge can also arrive in the final overlap cycle, so the clear and a re-arm coincide. The bench sweeps the lead from zero to several cycles, in both directions and with both sense values. It counts the high cycles of each pump command and compares the counts with d+OVL and OVL. A separate case asserts the hold while a retard pulse is active, to check that forcing and clearing win over the running state.

// File: rtl/pfd_pkg.sv
// Package: shared constants and the gain-code translation for the detector.
// Assumes gain codes are 2 bits and multipliers are expressed in half units.
package pfd_pkg;

    localparam int GAIN_W = 2;
    localparam int MULT_W = 4;

    // Translate a gain select code into the multiplier times two.
    function automatic logic [MULT_W-1:0] gain_half_units(input logic [GAIN_W-1:0] code);
        logic [MULT_W-1:0] r;
        case (code)
            2'b00:   r = MULT_W'(2);
            2'b01:   r = MULT_W'(3);
            2'b10:   r = MULT_W'(5);
            default: r = MULT_W'(8);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfd_edge.sv
// Module: rising-edge detector for a vector of synchronous pulse inputs.
// Assumes the inputs are already in the clk domain. The history resets to 0,
// so an input that is high when reset is released counts as an edge.
module pfd_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    // Remember the previous sample of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_in;
    end

    // One detector per input lane.
    for (genvar i = 0; i < N; i++) begin : g_lane
        assign rise[i] = sig_in[i] & ~prev_q[i];
    end

endmodule

// File: rtl/pfd_core.sv
// Module: two-flag phase-frequency state machine with a fixed overlap window.
// adv_q is armed by a reference edge and rtd_q by a divider edge. When both are
// set they stay set for OVL cycles and then clear. Edges seen in the clearing
// cycle re-arm their flag. A hold input clears everything.
module pfd_core #(
    parameter int OVL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ref_rise,
    input  logic div_rise,
    output logic adv,
    output logic rtd
);

    localparam int CW = (OVL > 1) ? $clog2(OVL) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVL - 1);

    logic          adv_q, rtd_q;
    logic [CW-1:0] ovl_cnt;
    logic          both;

    assign both = adv_q & rtd_q;

    // Arm flags on edges; time the overlap and clear both when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            adv_q   <= 1'b0;
            rtd_q   <= 1'b0;
            ovl_cnt <= '0;
        end else if (both) begin
            if (ovl_cnt == LAST) begin
                adv_q   <= ref_rise;
                rtd_q   <= div_rise;
                ovl_cnt <= '0;
            end else begin
                ovl_cnt <= ovl_cnt + 1'b1;
            end
        end else begin
            adv_q <= adv_q | ref_rise;
            rtd_q <= rtd_q | div_rise;
        end
    end

    assign adv = adv_q;
    assign rtd = rtd_q;

endmodule

// File: rtl/pfd_route.sv
// Module: polarity and monitor routing.
// With sense high, the advance flag sources current and the retard flag sinks
// it. Sense low swaps them. The monitor pins swap on the same bit. Hold gates
// both pump commands off within the same cycle.
module pfd_route
    import pfd_pkg::*;
(
    input  logic              sense,
    input  logic              hold,
    input  logic              adv,
    input  logic              rtd,
    input  logic              ref_in,
    input  logic              div_in,
    input  logic [GAIN_W-1:0] gain_code,
    output logic              pump_src,
    output logic              pump_snk,
    output logic              mon_a,
    output logic              mon_b,
    output logic [MULT_W-1:0] gain_x2
);

    // Map detector flags to pump directions under the polarity bit.
    always_comb begin
        pump_src = ~hold & (sense ? adv : rtd);
        pump_snk = ~hold & (sense ? rtd : adv);
    end

    // Route the divider signals to the monitor pins.
    always_comb begin
        mon_a = sense ? div_in : ref_in;
        mon_b = sense ? ref_in : div_in;
    end

    // Translate the gain select.
    assign gain_x2 = gain_half_units(gain_code);

endmodule

// File: rtl/pfd_sense_top.sv
// Module: top of the phase-frequency detector with sense control.
// Assumes ref_in and div_in are synchronous pulses that stay low for at least
// OVL+1 cycles between rising edges.
module pfd_sense_top
    import pfd_pkg::*;
#(
    parameter int OVL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              div_in,
    input  logic              sense,
    input  logic [GAIN_W-1:0] gain_code,
    input  logic              prog_hold,
    output logic              pump_src,
    output logic              pump_snk,
    output logic              mon_a,
    output logic              mon_b,
    output logic [MULT_W-1:0] gain_x2
);

    logic [1:0] rise;
    logic       adv, rtd;

    pfd_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({div_in, ref_in}),
        .rise   (rise)
    );

    pfd_core #(.OVL(OVL)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (prog_hold),
        .ref_rise (rise[0]),
        .div_rise (rise[1]),
        .adv      (adv),
        .rtd      (rtd)
    );

    pfd_route u_route (
        .sense     (sense),
        .hold      (prog_hold),
        .adv       (adv),
        .rtd       (rtd),
        .ref_in    (ref_in),
        .div_in    (div_in),
        .gain_code (gain_code),
        .pump_src  (pump_src),
        .pump_snk  (pump_snk),
        .mon_a     (mon_a),
        .mon_b     (mon_b),
        .gain_x2   (gain_x2)
    );

endmodule

// File: rtl/pfd_chk.sv
// Module: assertion checker attached to the detector top by bind.
// Assumes a synchronous active-low reset. Properties are disabled while it is low.
module pfd_chk #(
    parameter int OVL = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       div_in,
    input logic       prog_hold,
    input logic       pump_src,
    input logic       pump_snk,
    input logic [3:0] gain_x2
);

    localparam int BW = $clog2(OVL + 2);

    logic [BW-1:0] both_run;

    // Count consecutive cycles with both pump commands high.
    always_ff @(posedge clk) begin
        if (!rst_n)                   both_run <= '0;
        else if (pump_src && pump_snk) both_run <= both_run + 1'b1;
        else                          both_run <= '0;
    end

    a_r5_overlap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_src && pump_snk) |-> (both_run < BW'(OVL)));

    a_r8_quiet_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_hold) |-> (!pump_src && !pump_snk));

    a_r9_div_edge_acts: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_hold && $rose(div_in)) |=> (prog_hold || pump_src || pump_snk));

    a_r7_gain_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_x2 == 4'd2 || gain_x2 == 4'd3 || gain_x2 == 4'd5 || gain_x2 == 4'd8));

endmodule

bind pfd_sense_top pfd_chk #(.OVL(OVL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_in    (div_in),
    .prog_hold (prog_hold),
    .pump_src  (pump_src),
    .pump_snk  (pump_snk),
    .gain_x2   (gain_x2)
);

// File: tb/tb_pfd_sense_top.sv
module tb_pfd_sense_top;

    localparam int OVL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0, div_in = 1'b0, sense = 1'b1, prog_hold = 1'b0;
    logic [1:0] gain_code = 2'b00;
    logic       pump_src, pump_snk, mon_a, mon_b;
    logic [3:0] gain_x2;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pfd_sense_top #(.OVL(OVL)) dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in),
        .sense(sense), .gain_code(gain_code), .prog_hold(prog_hold),
        .pump_src(pump_src), .pump_snk(pump_snk), .mon_a(mon_a),
        .mon_b(mon_b), .gain_x2(gain_x2)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One edge on the leading input; the lagging edge follows d cycles later.
    task automatic trial(input bit s, input bit div_leads, input int d);
        int n_src = 0, n_snk = 0, n_lead, n_lag, exp_src, exp_snk;
        sense = s;
        for (int i = 0; i <= d + OVL + 4; i++) begin
            @(negedge clk);
            if (i > 0) begin
                n_src += pump_src;
                n_snk += pump_snk;
            end
            if (div_leads) begin div_in = (i == 0); ref_in = (i == d); end
            else           begin ref_in = (i == 0); div_in = (i == d); end
        end
        n_lead = d + OVL;
        n_lag  = OVL;
        // retard class follows the divider edge; advance class the reference
        if (div_leads == s) begin exp_snk = n_lead; exp_src = n_lag; end
        else                begin exp_src = n_lead; exp_snk = n_lag; end
        if (d == 0) begin
            check("R4 src width", n_src, OVL);
            check("R4 snk width", n_snk, OVL);
        end else if (div_leads) begin
            check("R2 src width", n_src, exp_src);
            check("R2 snk width", n_snk, exp_snk);
        end else begin
            check("R3 src width", n_src, exp_src);
            check("R3 snk width", n_snk, exp_snk);
        end
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 src in reset", pump_src, 0);
        check("R1 snk in reset", pump_snk, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 src after reset", pump_src, 0);
        check("R1 snk after reset", pump_snk, 0);

        // R2 / R3 / R4: sweep lead, direction and sense
        for (int s = 0; s < 2; s++)
            for (int dl = 0; dl < 2; dl++)
                for (int d = 0; d <= 6; d++)
                    trial(s[0], dl[0], d);

        // R6: monitor routing for all input and sense combinations
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            sense = k[2]; ref_in = k[1]; div_in = k[0];
            #1;
            check("R6 mon_a", mon_a, sense ? div_in : ref_in);
            check("R6 mon_b", mon_b, sense ? ref_in : div_in);
        end
        @(negedge clk); ref_in = 0; div_in = 0;
        repeat (4) @(negedge clk);

        // R7: gain mapping
        for (int g = 0; g < 4; g++) begin
            gain_code = g[1:0];
            #1;
            check("R7 gain_x2", gain_x2, (g == 0) ? 2 : (g == 1) ? 3 : (g == 2) ? 5 : 8);
        end

        // R8: hold while a retard pulse is active (sense=1 -> sink)
        sense = 1'b1;
        @(negedge clk); div_in = 1'b1;
        @(negedge clk); div_in = 1'b0;
        @(negedge clk);
        check("R8 snk active before hold", pump_snk, 1);
        prog_hold = 1'b1;
        #1;
        check("R8 snk forced off", pump_snk, 0);
        check("R8 src forced off", pump_src, 0);
        repeat (2) @(negedge clk);
        prog_hold = 1'b0;
        #1;
        check("R8 snk cleared on release", pump_snk, 0);
        @(negedge clk);
        check("R8 snk still clear", pump_snk, 0);
        check("R8 src still clear", pump_src, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule